// File: doc/BRIEF.md
# Paged Register File with Pointer/Data-Port Access

This block is the byte-wide register file of a peripheral controller as a local CPU sees it. The CPU has a 5-bit address bus, so it can reach only offsets 0x00 to 0x1F directly. Registers at offsets 0x20 and above are reached in two steps. The CPU first writes the target offset into a pointer register at direct offset 0x00. It then reads or writes a data port at direct offset 0x01, which forwards the access to the register the pointer names.

Part of the map is banked by endpoint. A page register at direct offset 0x04 chooses which endpoint's copy of the banked registers appears in the shared window. Some registers are read-only views of side-band status inputs. Others drive side-band control outputs toward the endpoint and device logic.

Reads are combinational from the registered state while chip select and the read strobe are both high. Writes land on the rising clock edge while chip select and the write strobe are both high.

Top module: `pgreg_file`

## Requirements
- R1: After reset the following all read 0x00: the pointer, the page register, every writable global register and every writable banked register. `page_o`, `ep_cfg_o`, `glb_ctrl_o` and `dev_addr_o` are all zero.
- R2: `cpu_rdata` is 0x00 whenever `cpu_cs` or `cpu_rd` is low. When both are high, it shows the addressed register in the same cycle.
- R3: Direct offsets 0x18, 0x19, 0x1C and 0x1D are writable and read back the last value written. Offset 0x1D is the scratch register. Offsets 0x18 and 0x19 drive the low and high bytes of `glb_ctrl_o`.
- R4: Direct offset 0x00 is the 8-bit pointer and reads back its value. Direct offset 0x01 reads or writes the register whose offset equals the pointer. The pointer is not changed by data-port accesses.
- R5: Direct offset 0x04 stores only its low log2(NUM_EP) bits, the endpoint page. It reads back zero-extended, and `page_o` carries the stored value.
- R6: Each endpoint has its own copy of direct offsets 0x05 and 0x07–0x0F and of pointer offsets 0x28–0x2C. A write reaches only the copy of the current page, and a read returns only that copy. Byte `ep_cfg_o[8e+7:8e]` is endpoint e's copy of offset 0x2A.
- R7: Pointer offsets 0x20–0x24 and 0x30–0x37 are single global registers, unaffected by the page. Offset 0x30 drives `dev_addr_o`.
- R8: Several offsets are read-only, and writes to them change nothing:
  - 0x02 and 0x03 return the low and high bytes of `evt_stat_i`.
  - 0x1A and 0x1B return the low and high bytes of `frame_i`.
  - 0x06 returns byte p of `ep_stat_i`, where p is the current page.
  - Pointer offset 0x25 returns the `CHIP_REV` parameter.
- R9: The following offsets are unimplemented. They read 0x00, and writes to them have no effect:
  - direct offsets 0x10–0x17, 0x1E and 0x1F;
  - pointer values below 0x20;
  - pointer values 0x26, 0x27, 0x2D–0x2F and 0x38 or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_cs | input | 1 | Chip select, active high |
| cpu_rd | input | 1 | Read strobe, active high |
| cpu_wr | input | 1 | Write strobe, active high |
| cpu_addr | input | 5 | CPU register address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, combinational |
| evt_stat_i | input | 16 | Event status view for offsets 0x02/0x03 |
| frame_i | input | 16 | Frame number view for offsets 0x1A/0x1B |
| ep_stat_i | input | NUM_EP*8 | Per-endpoint status byte, read at 0x06 |
| page_o | output | log2(NUM_EP) | Current endpoint page |
| ep_cfg_o | output | NUM_EP*8 | Each endpoint's configuration byte (0x2A) |
| glb_ctrl_o | output | 16 | Global control word (0x19:0x18) |
| dev_addr_o | output | 8 | Device address byte (0x30) |

## Verification
The bench builds the block with NUM_EP = 4 and CHIP_REV = 0x6B. Four endpoints make the page field two bits wide. A write of 0x07 to the page register must then read back as 0x03, and separate values can be placed in two different banks and seen apart on `ep_cfg_o`. The non-default revision value shows that the read-only identity byte comes from the parameter and not from storage. The bench also aims a pointer at the scratch offset to confirm that direct-only registers cannot be reached through the data port.

// File: rtl/pgreg_pkg.sv
package pgreg_pkg;

  localparam int unsigned DW        = 8;
  localparam int unsigned AW        = 5;
  localparam int unsigned IDX_W     = 5;
  localparam int unsigned EP_SLOTS  = 15;
  localparam int unsigned GLB_SLOTS = 17;
  localparam int unsigned EP_CFG_SLOT   = 12;
  localparam int unsigned GLB_CTRL_LO   = 0;
  localparam int unsigned GLB_CTRL_HI   = 1;
  localparam int unsigned GLB_DEV_ADDR  = 9;
  localparam logic [AW-1:0] ADDR_PTR  = 5'h00;
  localparam logic [AW-1:0] ADDR_PORT = 5'h01;
  localparam logic [AW-1:0] ADDR_PAGE = 5'h04;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_PTR, SRC_PAGE, SRC_GLB, SRC_EP, SRC_EXT, SRC_REV
  } src_e;

  typedef struct packed {
    src_e             src;
    logic [IDX_W-1:0] idx;
  } dec_t;

  // Maps an effective offset to a storage class and a slot inside it.
  function automatic dec_t decode(input logic via_port, input logic [DW-1:0] off);
    dec_t d;
    d.src = SRC_NONE;
    d.idx = '0;
    if (!(via_port && off < 8'h20)) begin
      case (off) inside
        8'h00:          d.src = SRC_PTR;
        8'h04:          d.src = SRC_PAGE;
        8'h02:          begin d.src = SRC_EXT; d.idx = 5'd0; end
        8'h03:          begin d.src = SRC_EXT; d.idx = 5'd1; end
        8'h1A:          begin d.src = SRC_EXT; d.idx = 5'd2; end
        8'h1B:          begin d.src = SRC_EXT; d.idx = 5'd3; end
        8'h06:          begin d.src = SRC_EXT; d.idx = 5'd4; end
        8'h18:          begin d.src = SRC_GLB; d.idx = 5'd0; end
        8'h19:          begin d.src = SRC_GLB; d.idx = 5'd1; end
        8'h1C:          begin d.src = SRC_GLB; d.idx = 5'd2; end
        8'h1D:          begin d.src = SRC_GLB; d.idx = 5'd3; end
        [8'h20:8'h24]:  begin d.src = SRC_GLB; d.idx = IDX_W'(off - 8'h20 + 8'd4); end
        8'h25:          d.src = SRC_REV;
        [8'h30:8'h37]:  begin d.src = SRC_GLB; d.idx = IDX_W'(off - 8'h30 + 8'd9); end
        8'h05:          begin d.src = SRC_EP;  d.idx = 5'd0; end
        [8'h07:8'h0F]:  begin d.src = SRC_EP;  d.idx = IDX_W'(off - 8'h06); end
        [8'h28:8'h2C]:  begin d.src = SRC_EP;  d.idx = IDX_W'(off - 8'h28 + 8'd10); end
        default:        d.src = SRC_NONE;
      endcase
    end
    return d;
  endfunction

endpackage

// File: rtl/pgreg_rst_sync.sv
module pgreg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/pgreg_ctl.sv
module pgreg_ctl #(
  parameter int unsigned DW = 8,
  parameter int unsigned PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_we,
  input  logic          page_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ptr_q,
  output logic [PW-1:0] page_q
);
  logic [DW-1:0] ptr_d;
  logic [PW-1:0] page_d;

  always_comb begin
    ptr_d  = ptr_q;
    page_d = page_q;
    if (ptr_we)  ptr_d  = wdata;
    if (page_we) page_d = wdata[PW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      page_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      page_q <= page_d;
    end
  end
endmodule

// File: rtl/pgreg_slots.sv
module pgreg_slots #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IW    = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [IW-1:0]             widx,
  input  logic [DW-1:0]             wdata,
  output logic [DEPTH-1:0][DW-1:0]  q
);
  logic [DEPTH-1:0] slot_en;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_comb slot_en[g] = we && (widx == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q[g] <= '0;
      else if (slot_en[g]) q[g] <= wdata;
    end
  end
endmodule

// File: rtl/pgreg_file.sv
module pgreg_file
  import pgreg_pkg::*;
#(
  parameter int unsigned NUM_EP   = 4,
  parameter logic [7:0]  CHIP_REV = 8'h15,
  localparam int unsigned PW      = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_cs,
  input  logic                cpu_rd,
  input  logic                cpu_wr,
  input  logic [4:0]          cpu_addr,
  input  logic [7:0]          cpu_wdata,
  output logic [7:0]          cpu_rdata,
  input  logic [15:0]         evt_stat_i,
  input  logic [15:0]         frame_i,
  input  logic [NUM_EP*8-1:0] ep_stat_i,
  output logic [PW-1:0]       page_o,
  output logic [NUM_EP*8-1:0] ep_cfg_o,
  output logic [15:0]         glb_ctrl_o,
  output logic [7:0]          dev_addr_o
);
  localparam int unsigned EP_IW = $clog2(EP_SLOTS);

  logic                                  rst_n_int;
  logic [DW-1:0]                         ptr_q;
  logic [PW-1:0]                         page_q;
  logic                                  via_port;
  logic [DW-1:0]                         eff_off;
  dec_t                                  dec;
  logic                                  wr_act;
  logic                                  ptr_we, page_we, glb_we;
  logic [NUM_EP-1:0]                     ep_we;
  logic [GLB_SLOTS-1:0][DW-1:0]          glb_q;
  logic [NUM_EP-1:0][EP_SLOTS-1:0][DW-1:0] ep_q;

  pgreg_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  // Address resolution: the data port substitutes the pointer value.
  always_comb begin
    via_port = (cpu_addr == ADDR_PORT);
    eff_off  = via_port ? ptr_q : DW'(cpu_addr);
    dec      = decode(via_port, eff_off);
  end

  // Write enables, one per storage class.
  always_comb begin
    wr_act  = cpu_cs && cpu_wr;
    ptr_we  = wr_act && (dec.src == SRC_PTR);
    page_we = wr_act && (dec.src == SRC_PAGE);
    glb_we  = wr_act && (dec.src == SRC_GLB);
    for (int e = 0; e < NUM_EP; e++) begin
      ep_we[e] = wr_act && (dec.src == SRC_EP) && (page_q == PW'(e));
    end
  end

  pgreg_ctl #(.DW(DW), .PW(PW)) i_ctl (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .ptr_we  (ptr_we),
    .page_we (page_we),
    .wdata   (cpu_wdata),
    .ptr_q   (ptr_q),
    .page_q  (page_q)
  );

  pgreg_slots #(.DW(DW), .DEPTH(GLB_SLOTS), .IW(IDX_W)) i_glb (
    .clk   (clk),
    .rst_n (rst_n_int),
    .we    (glb_we),
    .widx  (dec.idx),
    .wdata (cpu_wdata),
    .q     (glb_q)
  );

  for (genvar e = 0; e < NUM_EP; e++) begin : g_bank
    pgreg_slots #(.DW(DW), .DEPTH(EP_SLOTS), .IW(IDX_W)) i_bank (
      .clk   (clk),
      .rst_n (rst_n_int),
      .we    (ep_we[e]),
      .widx  (dec.idx),
      .wdata (cpu_wdata),
      .q     (ep_q[e])
    );
    assign ep_cfg_o[e*8 +: 8] = ep_q[e][EP_CFG_SLOT];
  end

  // Combinational read path.
  always_comb begin
    cpu_rdata = '0;
    if (cpu_cs && cpu_rd) begin
      case (dec.src)
        SRC_PTR:  cpu_rdata = ptr_q;
        SRC_PAGE: cpu_rdata = DW'(page_q);
        SRC_GLB:  cpu_rdata = glb_q[dec.idx];
        SRC_EP:   cpu_rdata = ep_q[page_q][dec.idx[EP_IW-1:0]];
        SRC_REV:  cpu_rdata = CHIP_REV;
        SRC_EXT: begin
          case (dec.idx[2:0])
            3'd0:    cpu_rdata = evt_stat_i[7:0];
            3'd1:    cpu_rdata = evt_stat_i[15:8];
            3'd2:    cpu_rdata = frame_i[7:0];
            3'd3:    cpu_rdata = frame_i[15:8];
            3'd4:    cpu_rdata = ep_stat_i[page_q*8 +: 8];
            default: cpu_rdata = '0;
          endcase
        end
        default:  cpu_rdata = '0;
      endcase
    end
  end

  assign page_o     = page_q;
  assign glb_ctrl_o = {glb_q[GLB_CTRL_HI], glb_q[GLB_CTRL_LO]};
  assign dev_addr_o = glb_q[GLB_DEV_ADDR];

endmodule

// File: rtl/pgreg_file_chk.sv
module pgreg_file_chk #(
  parameter int unsigned NUM_EP = 4,
  localparam int unsigned PW    = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cpu_cs,
  input logic                cpu_rd,
  input logic                cpu_wr,
  input logic [4:0]          cpu_addr,
  input logic [7:0]          cpu_wdata,
  input logic [7:0]          cpu_rdata,
  input logic [PW-1:0]       page_o,
  input logic [NUM_EP*8-1:0] ep_cfg_o,
  input logic [15:0]         glb_ctrl_o,
  input logic [7:0]          dev_addr_o
);

  // R2: bus idle means zero read data
  p_rdata_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_cs && cpu_rd) |-> cpu_rdata == 8'h00);

  // R3: direct write to 0x18 lands on the control word low byte
  p_ctrl_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_cs && cpu_wr && cpu_addr == 5'h18) |=> glb_ctrl_o[7:0] == $past(cpu_wdata));

  // R5: page loads from the low bits of the written byte
  p_page_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_cs && cpu_wr && cpu_addr == 5'h04) |=> page_o == $past(cpu_wdata[PW-1:0]));

  // R5: page holds without a write to 0x04
  p_page_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_cs && cpu_wr && cpu_addr == 5'h04) |=> $stable(page_o));

  // R7: device address changes only through the data port
  p_dev_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_cs && cpu_wr && cpu_addr == 5'h01) |=> $stable(dev_addr_o));

  // R6: an endpoint's config byte changes only when its page is selected
  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    p_ep_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_cs && cpu_wr && cpu_addr == 5'h01 && page_o == PW'(e))
      |=> $stable(ep_cfg_o[e*8 +: 8]));
  end

endmodule

bind pgreg_file pgreg_file_chk #(.NUM_EP(NUM_EP)) i_chk (.*);

// File: tb/test_pgreg_file.sv
module test_pgreg_file;
  localparam int unsigned NUM_EP = 4;
  localparam logic [7:0]  REV    = 8'h6B;
  localparam int unsigned NV     = 39;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                cpu_cs, cpu_rd, cpu_wr;
  logic [4:0]          cpu_addr;
  logic [7:0]          cpu_wdata;
  logic [7:0]          cpu_rdata;
  logic [15:0]         evt_stat_i, frame_i;
  logic [NUM_EP*8-1:0] ep_stat_i;
  logic [1:0]          page_o;
  logic [NUM_EP*8-1:0] ep_cfg_o;
  logic [15:0]         glb_ctrl_o;
  logic [7:0]          dev_addr_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  pgreg_file #(.NUM_EP(NUM_EP), .CHIP_REV(REV)) i_pgreg_file (
    .clk(clk), .rst_n(rst_n), .cpu_cs(cpu_cs), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .evt_stat_i(evt_stat_i), .frame_i(frame_i), .ep_stat_i(ep_stat_i),
    .page_o(page_o), .ep_cfg_o(ep_cfg_o), .glb_ctrl_o(glb_ctrl_o),
    .dev_addr_o(dev_addr_o)
  );

  // {is_read, addr, data_or_expected, requirement number}
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 5'h1D, 8'hA5, 4'd3},   // R3 scratch write
    {1'b1, 5'h1D, 8'hA5, 4'd3},   // R3 scratch readback
    {1'b0, 5'h18, 8'h3C, 4'd3},
    {1'b1, 5'h18, 8'h3C, 4'd3},
    {1'b0, 5'h19, 8'h81, 4'd3},
    {1'b0, 5'h00, 8'h30, 4'd4},   // R4 pointer -> 0x30
    {1'b0, 5'h01, 8'h5A, 4'd7},
    {1'b1, 5'h01, 8'h5A, 4'd7},   // R7 global via port
    {1'b1, 5'h00, 8'h30, 4'd4},   // R4 pointer held
    {1'b0, 5'h04, 8'h02, 4'd5},
    {1'b0, 5'h05, 8'h11, 4'd6},
    {1'b1, 5'h05, 8'h11, 4'd6},   // R6 bank 2 direct
    {1'b0, 5'h00, 8'h2A, 4'd4},
    {1'b0, 5'h01, 8'hC3, 4'd6},
    {1'b0, 5'h04, 8'h01, 4'd5},
    {1'b1, 5'h01, 8'h00, 4'd6},   // R6 bank 1 untouched
    {1'b1, 5'h05, 8'h00, 4'd6},
    {1'b0, 5'h01, 8'h77, 4'd6},
    {1'b1, 5'h01, 8'h77, 4'd6},
    {1'b0, 5'h04, 8'h02, 4'd5},
    {1'b1, 5'h01, 8'hC3, 4'd6},   // R6 bank 2 kept
    {1'b1, 5'h05, 8'h11, 4'd6},
    {1'b0, 5'h04, 8'h07, 4'd5},
    {1'b1, 5'h04, 8'h03, 4'd5},   // R5 truncated page
    {1'b0, 5'h00, 8'h22, 4'd7},
    {1'b0, 5'h01, 8'h9E, 4'd7},
    {1'b0, 5'h04, 8'h00, 4'd5},
    {1'b1, 5'h01, 8'h9E, 4'd7},   // R7 not banked
    {1'b0, 5'h00, 8'h26, 4'd9},
    {1'b0, 5'h01, 8'hFF, 4'd9},
    {1'b1, 5'h01, 8'h00, 4'd9},   // R9 hole via port
    {1'b0, 5'h1E, 8'h55, 4'd9},
    {1'b1, 5'h1E, 8'h00, 4'd9},   // R9 direct hole
    {1'b0, 5'h00, 8'h25, 4'd8},
    {1'b0, 5'h01, 8'h00, 4'd8},
    {1'b1, 5'h01, REV,   4'd8},   // R8 revision ignores write
    {1'b0, 5'h00, 8'h1D, 4'd9},
    {1'b1, 5'h01, 8'h00, 4'd9},   // R9 pointer below 0x20
    {1'b1, 5'h1D, 8'hA5, 4'd9}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_cs = 1'b1; cpu_wr = 1'b1; cpu_rd = 1'b0; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_cs = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_cs = 1'b1; cpu_rd = 1'b1; cpu_wr = 1'b0; cpu_addr = a;
    #1 d = cpu_rdata;
    @(negedge clk);
    cpu_cs = 1'b0; cpu_rd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    cpu_cs = 0; cpu_rd = 0; cpu_wr = 0; cpu_addr = '0; cpu_wdata = '0;
    evt_stat_i = '0; frame_i = '0; ep_stat_i = '0;
    rst_n = 1'b0;
    do_reset();

    // R1: reset state
    bus_rd(5'h1D, rv); check("R1 scratch", rv, 8'h00);
    bus_rd(5'h00, rv); check("R1 pointer", rv, 8'h00);
    bus_rd(5'h04, rv); check("R1 page", rv, 8'h00);
    check("R1 outputs", {page_o, ep_cfg_o, glb_ctrl_o, dev_addr_o}, '0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][17]) begin
        bus_rd(VEC[i][16:12], rv);
        check($sformatf("R%0d vector %0d", VEC[i][3:0], i), rv, VEC[i][11:4]);
      end else begin
        bus_wr(VEC[i][16:12], VEC[i][11:4]);
      end
    end

    // R3 / R6 / R7: side-band outputs after the table
    check("R3 glb_ctrl_o", glb_ctrl_o, 16'h813C);
    check("R7 dev_addr_o", dev_addr_o, 8'h5A);
    check("R6 ep_cfg_o", ep_cfg_o, 32'h00C3_7700);

    // R8: read-only side-band views
    evt_stat_i = 16'hBEEF; frame_i = 16'h0123; ep_stat_i = 32'h4433_2211;
    bus_rd(5'h02, rv); check("R8 evt lo", rv, 8'hEF);
    bus_rd(5'h03, rv); check("R8 evt hi", rv, 8'hBE);
    bus_rd(5'h1A, rv); check("R8 frame lo", rv, 8'h23);
    bus_rd(5'h1B, rv); check("R8 frame hi", rv, 8'h01);
    bus_rd(5'h06, rv); check("R8 ep stat page0", rv, 8'h11);
    bus_wr(5'h04, 8'h03);
    bus_rd(5'h06, rv); check("R8 ep stat page3", rv, 8'h44);
    bus_wr(5'h06, 8'h00);
    bus_wr(5'h1A, 8'hFF);
    bus_rd(5'h06, rv); check("R8 ep stat write ignored", rv, 8'h44);
    bus_rd(5'h1A, rv); check("R8 frame write ignored", rv, 8'h23);

    // R2: read data gated by chip select and read strobe
    @(negedge clk);
    cpu_cs = 1'b1; cpu_rd = 1'b0; cpu_addr = 5'h1D;
    #1 check("R2 rd low", cpu_rdata, 8'h00);
    cpu_cs = 1'b0; cpu_rd = 1'b1;
    #1 check("R2 cs low", cpu_rdata, 8'h00);
    cpu_cs = 1'b1;
    #1 check("R2 both high", cpu_rdata, 8'hA5);
    @(negedge clk);
    cpu_cs = 1'b0; cpu_rd = 1'b0;

    // R1: reset again clears everything written
    do_reset();
    bus_rd(5'h1D, rv); check("R1 scratch after reset", rv, 8'h00);
    bus_rd(5'h00, rv); check("R1 pointer after reset", rv, 8'h00);
    check("R1 outputs after reset", {page_o, ep_cfg_o, glb_ctrl_o, dev_addr_o}, '0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule